// File: doc/BRIEF.md
# Dual Instruction-Set State Controller

This block keeps track of which of two instruction encodings a small processor is currently fetching: a wide state where every instruction is 32 bits, and a compact state where instructions are 16 bits and are later widened by a separate expansion stage. The active state lives in one bit of a current status register. The block owns the program counter and reports the fetch size that matches the active state. Execution behaves the same in both states.

Three events can redirect the state and the PC. A branch-with-exchange takes its new state from the lowest bit of the target address. Exception entry always drops back to the wide state, jumps to a vector and saves a copy of the current status. Exception return reloads the whole status, including the state bit, from a saved status word supplied on the input side, and resumes at a return address. When nothing redirects, the PC steps by one instruction of the active width.

Top module: `isa_state_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the state bit, the whole `status` word, `saved_status` and `pc` all become 0 (reset vector 0, wide state).
- R2: On a branch-with-exchange (`bx_valid`) with no higher-priority event, the state bit takes `bx_target[0]` (0 = wide, 1 = compact) and `pc` takes `bx_target` with bit 0 cleared in the compact state, or bits 1:0 cleared in the wide state.
- R3: On exception entry (`exc_valid`), the state bit becomes 0 whatever it was, the other status bits are kept, and `pc` takes `exc_vector` with bits 1:0 cleared.
- R4: On exception entry, `saved_status` takes the value `status` had just before that edge; no other event changes `saved_status`.
- R5: On exception return (`eret_valid`) with no exception entry, `status` is loaded entirely from `saved_status_in` (state bit at position `STATE_BIT` = 0), and `pc` takes `eret_addr` aligned for the restored state as in R2.
- R6: When events coincide, exception entry wins over exception return, which wins over branch-with-exchange; the losing events have no effect.
- R7: With no event, `pc` advances by 4 in the wide state and by 2 in the compact state, wrapping modulo 2^32, and `status` is unchanged.
- R8: `fetch_half` is 1 (halfword fetch) exactly when the state bit is 1, and 0 (word fetch) when it is 0.
- R9: `pc[1:0]` is 0 in the wide state and `pc[0]` is 0 in the compact state at all times.
- R10: Every update caused by an input at a clock edge is visible on the outputs right after that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bx_valid | input | 1 | Branch-with-exchange strobe |
| bx_target | input | 32 | Branch target; bit 0 selects the new state |
| exc_valid | input | 1 | Exception entry strobe |
| exc_vector | input | 32 | Exception vector address |
| eret_valid | input | 1 | Exception return strobe |
| eret_addr | input | 32 | Return address for exception return |
| saved_status_in | input | 8 | Saved status word to restore on exception return |
| pc | output | 32 | Current fetch address |
| isa_state | output | 1 | Active state: 0 wide, 1 compact |
| fetch_half | output | 1 | Fetch size: 0 word, 1 halfword |
| status | output | 8 | Current status register |
| saved_status | output | 8 | Status copy captured at exception entry |

## Verification
Every registered result (PC, status, saved copy) is due exactly one clock edge after the inputs that cause it, while `fetch_half` follows the state bit combinationally in the same cycle. The bench drives inputs at the falling edge, advances its own reference model at the following rising edge from the inputs it just applied, and compares all outputs at the next falling edge, so each comparison lands one edge after its stimulus and away from the active edge. Random event mixes are interleaved with directed cases for simultaneous events, PC wrap and odd/even targets.

// File: rtl/isa_pkg.sv
package isa_pkg;

    localparam int ADDR_W    = 32;
    localparam int STAT_W    = 8;
    localparam int STATE_BIT = 0;

    localparam logic [ADDR_W-1:0] RESET_PC  = '0;
    localparam logic [ADDR_W-1:0] STEP_WIDE = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] STEP_HALF = ADDR_W'(2);

    typedef enum logic {
        ISA_WIDE    = 1'b0,
        ISA_COMPACT = 1'b1
    } isa_e;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_BX   = 2'd1,
        EV_ERET = 2'd2,
        EV_EXC  = 2'd3
    } event_e;

    typedef struct packed {
        event_e             ev;
        logic [ADDR_W-1:0]  addr;
        isa_e               next_isa;
        logic [STAT_W-1:0]  load_status;
    } redirect_t;

    function automatic logic [ADDR_W-1:0] align_pc(input logic [ADDR_W-1:0] a, input isa_e s);
        logic [ADDR_W-1:0] r;
        r = a;
        r[0] = 1'b0;
        if (s == ISA_WIDE) r[1] = 1'b0;
        return r;
    endfunction

    function automatic logic [ADDR_W-1:0] step_of(input isa_e s);
        return (s == ISA_COMPACT) ? STEP_HALF : STEP_WIDE;
    endfunction

endpackage

// File: rtl/isa_event_arb.sv
module isa_event_arb
    import isa_pkg::*;
(
    input  logic              bx_valid,
    input  logic [ADDR_W-1:0] bx_target,
    input  logic              exc_valid,
    input  logic [ADDR_W-1:0] exc_vector,
    input  logic              eret_valid,
    input  logic [ADDR_W-1:0] eret_addr,
    input  logic [STAT_W-1:0] saved_status_in,
    input  isa_e              cur_isa,
    output redirect_t         redir
);
    always_comb begin
        redir.ev          = EV_NONE;
        redir.addr        = '0;
        redir.next_isa    = cur_isa;
        redir.load_status = saved_status_in;
        if (exc_valid) begin
            redir.ev       = EV_EXC;
            redir.addr     = exc_vector;
            redir.next_isa = ISA_WIDE;
        end else if (eret_valid) begin
            redir.ev       = EV_ERET;
            redir.addr     = eret_addr;
            redir.next_isa = isa_e'(saved_status_in[STATE_BIT]);
        end else if (bx_valid) begin
            redir.ev       = EV_BX;
            redir.addr     = bx_target;
            redir.next_isa = isa_e'(bx_target[0]);
        end
    end
endmodule

// File: rtl/isa_pc_unit.sv
module isa_pc_unit
    import isa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  redirect_t         redir,
    input  isa_e              cur_isa,
    output logic [ADDR_W-1:0] pc_q
);
    logic [ADDR_W-1:0] pc_d;

    always_comb begin
        if (redir.ev != EV_NONE)
            pc_d = align_pc(redir.addr, redir.next_isa);
        else
            pc_d = pc_q + step_of(cur_isa);
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= RESET_PC;
        else     pc_q <= pc_d;
    end
endmodule

// File: rtl/isa_status_unit.sv
module isa_status_unit
    import isa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  redirect_t         redir,
    output logic [STAT_W-1:0] status_q,
    output logic [STAT_W-1:0] saved_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            saved_q  <= '0;
        end else begin
            unique case (redir.ev)
                EV_EXC: begin
                    saved_q             <= status_q;
                    status_q[STATE_BIT] <= 1'(ISA_WIDE);
                end
                EV_ERET: status_q <= redir.load_status;
                EV_BX:   status_q[STATE_BIT] <= 1'(redir.next_isa);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/isa_state_ctrl.sv
module isa_state_ctrl
    import isa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bx_valid,
    input  logic [ADDR_W-1:0] bx_target,
    input  logic              exc_valid,
    input  logic [ADDR_W-1:0] exc_vector,
    input  logic              eret_valid,
    input  logic [ADDR_W-1:0] eret_addr,
    input  logic [STAT_W-1:0] saved_status_in,
    output logic [ADDR_W-1:0] pc,
    output logic              isa_state,
    output logic              fetch_half,
    output logic [STAT_W-1:0] status,
    output logic [STAT_W-1:0] saved_status
);
    redirect_t redir;
    isa_e      cur_isa;

    assign cur_isa = isa_e'(status[STATE_BIT]);

    isa_event_arb u_arb (
        .bx_valid        (bx_valid),
        .bx_target       (bx_target),
        .exc_valid       (exc_valid),
        .exc_vector      (exc_vector),
        .eret_valid      (eret_valid),
        .eret_addr       (eret_addr),
        .saved_status_in (saved_status_in),
        .cur_isa         (cur_isa),
        .redir           (redir)
    );

    isa_pc_unit u_pc (
        .clk     (clk),
        .rst     (rst),
        .redir   (redir),
        .cur_isa (cur_isa),
        .pc_q    (pc)
    );

    isa_status_unit u_stat (
        .clk      (clk),
        .rst      (rst),
        .redir    (redir),
        .status_q (status),
        .saved_q  (saved_status)
    );

    assign isa_state  = 1'(cur_isa);
    assign fetch_half = (cur_isa == ISA_COMPACT);
endmodule

// File: rtl/isa_state_ctrl_chk.sv
module isa_state_ctrl_chk
    import isa_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bx_valid,
    input logic [ADDR_W-1:0] bx_target,
    input logic              exc_valid,
    input logic              eret_valid,
    input logic [STAT_W-1:0] saved_status_in,
    input logic [ADDR_W-1:0] pc,
    input logic              isa_state,
    input logic              fetch_half,
    input logic [STAT_W-1:0] status,
    input logic [STAT_W-1:0] saved_status
);
    // R3
    exc_to_wide_chk: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> (isa_state == 1'b0 && pc[1:0] == 2'b00));

    // R4
    saved_copy_chk: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> (saved_status == $past(status)));

    // R4
    saved_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!exc_valid && !$past(rst)) |=> $stable(saved_status));

    // R5 R6
    eret_restore_chk: assert property (@(posedge clk) disable iff (rst)
        (eret_valid && !exc_valid) |=> (status == $past(saved_status_in)));

    // R2 R6
    bx_state_chk: assert property (@(posedge clk) disable iff (rst)
        (bx_valid && !eret_valid && !exc_valid) |=> (isa_state == $past(bx_target[0])));

    // R7
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!bx_valid && !eret_valid && !exc_valid) |=>
            ($stable(status) && pc == $past(pc) + ($past(isa_state) ? 32'd2 : 32'd4)));

    // R8
    fetch_size_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_half == isa_state);

    // R9
    pc_align_chk: assert property (@(posedge clk) disable iff (rst)
        (pc[0] == 1'b0) && (isa_state || pc[1] == 1'b0));
endmodule

bind isa_state_ctrl isa_state_ctrl_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .bx_valid        (bx_valid),
    .bx_target       (bx_target),
    .exc_valid       (exc_valid),
    .eret_valid      (eret_valid),
    .saved_status_in (saved_status_in),
    .pc              (pc),
    .isa_state       (isa_state),
    .fetch_half      (fetch_half),
    .status          (status),
    .saved_status    (saved_status)
);

// File: tb/isa_state_ctrl_test.sv
module isa_state_ctrl_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        bx_valid, exc_valid, eret_valid;
    logic [31:0] bx_target, exc_vector, eret_addr;
    logic [7:0]  saved_status_in;
    logic [31:0] pc;
    logic        isa_state, fetch_half;
    logic [7:0]  status, saved_status;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [31:0] m_pc;
    logic [7:0]  m_stat, m_saved;
    string       m_tag;

    always #10 clk = ~clk;

    isa_state_ctrl uut (
        .clk(clk), .rst(rst),
        .bx_valid(bx_valid), .bx_target(bx_target),
        .exc_valid(exc_valid), .exc_vector(exc_vector),
        .eret_valid(eret_valid), .eret_addr(eret_addr),
        .saved_status_in(saved_status_in),
        .pc(pc), .isa_state(isa_state), .fetch_half(fetch_half),
        .status(status), .saved_status(saved_status)
    );

    function automatic logic [31:0] aligned(input logic [31:0] a, input logic compact);
        return compact ? {a[31:1], 1'b0} : {a[31:2], 2'b00};
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // next model state from current model and applied inputs (R2..R7)
    task automatic model_step();
        int nev;
        nev = int'(bx_valid) + int'(exc_valid) + int'(eret_valid);
        if (exc_valid) begin
            m_saved   = m_stat;
            m_stat[0] = 1'b0;
            m_pc      = aligned(exc_vector, 1'b0);
            m_tag     = "R3 R4";
        end else if (eret_valid) begin
            m_stat = saved_status_in;
            m_pc   = aligned(eret_addr, saved_status_in[0]);
            m_tag  = "R5";
        end else if (bx_valid) begin
            m_stat[0] = bx_target[0];
            m_pc      = aligned(bx_target, bx_target[0]);
            m_tag     = "R2";
        end else begin
            m_pc  = m_pc + (m_stat[0] ? 32'd2 : 32'd4);
            m_tag = "R7";
        end
        if (nev > 1) m_tag = {m_tag, " R6"};
    endtask

    task automatic compare_all();
        string t;
        t = {m_tag, " R10"};
        check(t, "pc", pc, m_pc);
        check(t, "status", {24'd0, status}, {24'd0, m_stat});
        check("R4", "saved_status", {24'd0, saved_status}, {24'd0, m_saved});
        check("R8", "fetch_half", {31'd0, fetch_half}, {31'd0, m_stat[0]});
        check("R9", "pc alignment", {30'd0, pc[1:0] & {~isa_state, 1'b1}}, 32'd0);
    endtask

    // drive at falling edge, model at rising edge, compare at next falling edge
    task automatic cycle(input logic b, input logic [31:0] bt, input logic e, input logic [31:0] ev,
                         input logic r, input logic [31:0] ra, input logic [7:0] ss);
        bx_valid = b; bx_target = bt; exc_valid = e; exc_vector = ev;
        eret_valid = r; eret_addr = ra; saved_status_in = ss;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0, 8'h00);
    endtask

    initial begin
        rst = 1'b1;
        bx_valid = 0; exc_valid = 0; eret_valid = 0;
        bx_target = 32'hFFFF_FFFF; exc_vector = 32'h0; eret_addr = 32'h0; saved_status_in = 8'hFF;
        repeat (2) @(posedge clk);
        @(negedge clk);
        m_pc = 32'h0; m_stat = 8'h0; m_saved = 8'h0; m_tag = "R1";
        check("R1", "pc", pc, 32'h0);
        check("R1", "status", {24'd0, status}, 32'h0);
        check("R1", "saved_status", {24'd0, saved_status}, 32'h0);
        check("R1", "isa_state", {31'd0, isa_state}, 32'h0);
        rst = 1'b0;

        // R7 wide stepping
        idle(3);
        // R2 odd target -> compact, halfword steps
        cycle(1'b1, 32'h0000_1003, 0, 0, 0, 0, 0);
        idle(3);
        // R2 even target with bit1 set -> wide, bits 1:0 cleared
        cycle(1'b1, 32'h0000_2006, 0, 0, 0, 0, 0);
        idle(2);
        // R3 R4 exception from compact state, other status bits kept
        cycle(0, 0, 0, 0, 1'b1, 32'h0000_0401, 8'hA5);
        cycle(0, 0, 1'b1, 32'h0000_001F, 0, 0, 0);
        idle(2);
        // R5 return restores compact state and aligns return address
        cycle(0, 0, 0, 0, 1'b1, 32'h0000_3003, 8'h81);
        idle(2);
        // R6 all three together: exception wins
        cycle(1'b1, 32'h5555_5555, 1'b1, 32'h0000_0100, 1'b1, 32'h7777_7777, 8'h3F);
        // R6 return beats branch
        cycle(1'b1, 32'h0000_0008, 0, 0, 1'b1, 32'h0000_9001, 8'h01);
        // R7 wrap in compact state
        cycle(1'b1, 32'hFFFF_FFFD, 0, 0, 0, 0, 0);
        idle(2);
        cycle(1'b1, 32'hFFFF_FFF8, 0, 0, 0, 0, 0);
        idle(3);

        begin
            int unsigned seed = $urandom(32'd1957);
            for (int i = 0; i < 2000; i++) begin
                logic [3:0] sel;
                sel = 4'($urandom());
                cycle(sel == 4'd1 || sel == 4'd4 || sel == 4'd6 || sel == 4'd7, $urandom(),
                      sel == 4'd2 || sel == 4'd5 || sel == 4'd7, $urandom(),
                      sel == 4'd3 || sel == 4'd5 || sel == 4'd6 || sel == 4'd7, $urandom(),
                      8'($urandom()));
            end
            seed = seed + 1;
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule